// File: doc/BRIEF.md
# Strobe-Qualified Core Reset and Interrupt Router

This block receives a request from off-chip pads and turns it into a one-cycle non-maskable interrupt pulse or a one-cycle local-reset pulse for one of eight processor cores, or for all of them. The request has four parts: a 4-bit select bus, an active-low local-reset line, an active-low interrupt line and an active-low qualifying strobe. Every pad input first passes through a two-flop synchronizer running on the system clock.

A request counts only when it is well formed. The select and request lines must be quiet for a minimum number of clocks before the strobe falls. They must not move while the strobe is low. The strobe must stay low for at least the same minimum, and the lines must stay quiet for that window again after the strobe rises. The action is committed when the strobe rises. A malformed request is dropped and raises a sticky error flag, which a clear input removes. A select code with its top bit set reaches every core.

Top module: `core_event_router`

## Requirements
- R1: Select codes 0 to 7 (top bit of the 4-bit code clear) address only the core whose index equals the low three bits. Any code with bit 3 set addresses all eight cores together.
- R2: When the strobe is low, the reset line is high and the interrupt line is low, a valid request pulses the interrupt output bit of each addressed core.
- R3: When the reset line is low in a valid request, the reset output bit of each addressed core is pulsed and no interrupt bit is pulsed, even if the interrupt line is also low.
- R4: A valid request with both the reset and interrupt lines high produces no pulse and no error.
- R5: Each addressed core gets exactly one pulse, one cycle wide. It is visible after the third rising clock edge that follows the strobe pad going high (two synchronizer stages plus one output register).
- R6: The strobe must be low for at least 12 synchronized cycles. A low time of 12 is accepted. A shorter low time drops the request and sets the error flag.
- R7: A change on the select, reset or interrupt line while the strobe is low drops the request and sets the error flag.
- R8: If the select, reset and interrupt lines are not stable for 12 cycles before the strobe falls, the request is dropped and the error flag is set.
- R9: A change on the select, reset or interrupt line within 12 cycles after the strobe rises sets the error flag. The pulses already committed still go out.
- R10: The error flag stays set until the clear input is high at a rising clock edge. It reads low from the cycle after that edge, unless a new error arrives in the same cycle.
- R11: A synchronous active-high reset clears both pulse vectors and the error flag. If the strobe is already low when reset is released, that low phase is ignored. Only a fresh high-to-low transition starts a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pad | input | 4 | Core select from pad; bit 3 means broadcast |
| lrst_n_pad | input | 1 | Local-reset request from pad, active low |
| nmi_n_pad | input | 1 | Interrupt request from pad, active low |
| stb_n_pad | input | 1 | Qualifying strobe from pad, active low |
| err_clr | input | 1 | Clears the error flag, synchronous |
| nmi_pulse | output | 8 | One-cycle interrupt pulse per core |
| lrst_pulse | output | 8 | One-cycle local-reset pulse per core |
| err_flag | output | 1 | Sticky malformed-request flag |

## Verification
A committed pulse and any width error caused by the strobe rising both appear after the third rising edge that follows the strobe pad rising. The bench samples each output on the falling edge of every cycle across a 24-cycle window after the rise. It requires the expected vector in window slot 3 and zeros in every other slot, so an early, late or repeated pulse fails the check. The error flag is read at the end of the window, which shows that it is sticky. The bench then clears it and checks it one falling edge after the clear edge.

// File: rtl/cer_pkg.sv
package cer_pkg;

   typedef enum logic [2:0] {
      QS_ARM,
      QS_IDLE,
      QS_LOW,
      QS_ABORT,
      QS_HOLD
   } qual_state_t;

   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_NMI,
      ACT_LRST
   } act_t;

endpackage

// File: rtl/cer_sync.sv
module cer_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cer_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cer_qualifier.sv
module cer_qualifier
   import cer_pkg::*;
#(
   parameter int SEL_W      = 4,
   parameter int MIN_CYCLES = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stb_n,
   input  logic             lrst_n,
   input  logic             nmi_n,
   input  logic [SEL_W-1:0] sel,
   output logic             commit,
   output act_t             commit_act,
   output logic [SEL_W-1:0] commit_sel,
   output logic             viol
);

   localparam int BW    = SEL_W + 2;
   localparam int CNT_W = $clog2(MIN_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_CYCLES - 1);

   qual_state_t      state, state_nxt;
   logic [BW-1:0]    bundle, bundle_q;
   logic             stb_q;
   logic [CNT_W-1:0] stab_cnt, low_cnt, hold_cnt;
   logic             changed, fall, setup_ok;

   assign bundle   = {sel, lrst_n, nmi_n};
   assign changed  = (bundle != bundle_q);
   assign fall     = stb_q & ~stb_n;
   assign setup_ok = !changed && (stab_cnt >= CNT_MIN);

   // Input history and counters
   always_ff @(posedge clk) begin
      if (rst) begin
         bundle_q <= {{SEL_W{1'b0}}, 2'b11};
         stb_q    <= 1'b0;
         stab_cnt <= '0;
      end else begin
         bundle_q <= bundle;
         stb_q    <= stb_n;
         if (changed) begin
            stab_cnt <= '0;
         end else if (stab_cnt < CNT_MIN) begin
            stab_cnt <= stab_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         low_cnt <= '0;
      end else if (state == QS_IDLE && fall) begin
         low_cnt <= CNT_W'(1);
      end else if (state == QS_LOW && !stb_n && low_cnt < CNT_MIN) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || state != QS_HOLD) begin
         hold_cnt <= '0;
      end else begin
         hold_cnt <= hold_cnt + 1'b1;
      end
   end

   // Request state machine
   always_comb begin
      state_nxt = state;
      commit    = 1'b0;
      viol      = 1'b0;
      unique case (state)
         QS_ARM: begin
            if (stb_n) state_nxt = QS_IDLE;
         end
         QS_IDLE: begin
            if (fall) begin
               if (setup_ok) begin
                  state_nxt = QS_LOW;
               end else begin
                  viol      = 1'b1;
                  state_nxt = QS_ABORT;
               end
            end
         end
         QS_LOW: begin
            if (changed) begin
               viol      = 1'b1;
               state_nxt = stb_n ? QS_IDLE : QS_ABORT;
            end else if (stb_n) begin
               if (low_cnt >= CNT_MIN) begin
                  commit    = 1'b1;
                  state_nxt = QS_HOLD;
               end else begin
                  viol      = 1'b1;
                  state_nxt = QS_IDLE;
               end
            end
         end
         QS_ABORT: begin
            if (stb_n) state_nxt = QS_IDLE;
         end
         QS_HOLD: begin
            if (changed || !stb_n) begin
               viol      = 1'b1;
               state_nxt = stb_n ? QS_IDLE : QS_ABORT;
            end else if (hold_cnt == CNT_LAST) begin
               state_nxt = QS_IDLE;
            end
         end
         default: state_nxt = QS_ARM;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= QS_ARM;
      else     state <= state_nxt;
   end

   always_comb begin
      if (!lrst_n)     commit_act = ACT_LRST;
      else if (!nmi_n) commit_act = ACT_NMI;
      else             commit_act = ACT_NONE;
   end

   assign commit_sel = sel;

   AST_COMMIT_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
      commit |-> !stb_q) else $error("commit without low strobe"); // R6

   AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      (state == QS_HOLD) |-> (hold_cnt < CNT_MIN)) else $error("hold overrun"); // R9

endmodule

// File: rtl/cer_fanout.sv
module cer_fanout
   import cer_pkg::*;
#(
   parameter int NUM_CORES = 8,
   parameter int SEL_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 commit,
   input  act_t                 act,
   input  logic [SEL_W-1:0]     sel,
   output logic [NUM_CORES-1:0] nmi_pulse,
   output logic [NUM_CORES-1:0] lrst_pulse
);

   localparam int IDX_W = SEL_W - 1;

   logic [NUM_CORES-1:0] target;
   logic                 bcast;
   logic [IDX_W-1:0]     idx;

   assign bcast = sel[SEL_W-1];
   assign idx   = sel[IDX_W-1:0];

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
         assign target[c] = bcast || (idx == IDX_W'(c));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         nmi_pulse  <= '0;
         lrst_pulse <= '0;
      end else begin
         nmi_pulse  <= (commit && act == ACT_NMI)  ? target : '0;
         lrst_pulse <= (commit && act == ACT_LRST) ? target : '0;
      end
   end

   AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (nmi_pulse != '0) |=> (nmi_pulse == '0)) else $error("nmi pulse too long"); // R5

   AST_LRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (lrst_pulse != '0) |=> (lrst_pulse == '0)) else $error("lrst pulse too long"); // R5

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
      !((nmi_pulse != '0) && (lrst_pulse != '0))) else $error("both kinds"); // R3

   AST_SHAPE: assert property (@(posedge clk) disable iff (rst)
      ($onehot0(nmi_pulse) || (&nmi_pulse)) && ($onehot0(lrst_pulse) || (&lrst_pulse)))
      else $error("bad pulse shape"); // R1

endmodule

// File: rtl/core_event_router.sv
module core_event_router
   import cer_pkg::*;
#(
   parameter int  NUM_CORES   = 8,
   parameter int  MIN_CYCLES  = 12,
   parameter int  SYNC_STAGES = 2,
   localparam int SEL_W       = $clog2(NUM_CORES) + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [SEL_W-1:0]     sel_pad,
   input  logic                 lrst_n_pad,
   input  logic                 nmi_n_pad,
   input  logic                 stb_n_pad,
   input  logic                 err_clr,
   output logic [NUM_CORES-1:0] nmi_pulse,
   output logic [NUM_CORES-1:0] lrst_pulse,
   output logic                 err_flag
);

   generate
      if (NUM_CORES < 2 || (NUM_CORES & (NUM_CORES - 1)) != 0) begin : g_bad_cores
         $error("core_event_router: NUM_CORES must be a power of two >= 2");
      end
      if (MIN_CYCLES < 2) begin : g_bad_min
         $error("core_event_router: MIN_CYCLES must be at least 2");
      end
   endgenerate

   logic [SEL_W-1:0] s_sel;
   logic             s_lrst_n, s_nmi_n, s_stb_n;
   logic             commit, viol;
   act_t             commit_act;
   logic [SEL_W-1:0] commit_sel;

   cer_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_sel (
      .clk(clk), .rst(rst), .d(sel_pad), .q(s_sel));
   cer_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lrst (
      .clk(clk), .rst(rst), .d(lrst_n_pad), .q(s_lrst_n));
   cer_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nmi (
      .clk(clk), .rst(rst), .d(nmi_n_pad), .q(s_nmi_n));
   // Strobe chain resets to "low" so a strobe held low through reset is never seen falling.
   cer_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_stb (
      .clk(clk), .rst(rst), .d(stb_n_pad), .q(s_stb_n));

   cer_qualifier #(.SEL_W(SEL_W), .MIN_CYCLES(MIN_CYCLES)) u_qual (
      .clk(clk), .rst(rst), .stb_n(s_stb_n), .lrst_n(s_lrst_n), .nmi_n(s_nmi_n),
      .sel(s_sel), .commit(commit), .commit_act(commit_act),
      .commit_sel(commit_sel), .viol(viol));

   cer_fanout #(.NUM_CORES(NUM_CORES), .SEL_W(SEL_W)) u_fanout (
      .clk(clk), .rst(rst), .commit(commit), .act(commit_act), .sel(commit_sel),
      .nmi_pulse(nmi_pulse), .lrst_pulse(lrst_pulse));

   always_ff @(posedge clk) begin
      if (rst)          err_flag <= 1'b0;
      else if (viol)    err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      (err_flag && !err_clr) |=> err_flag) else $error("error flag dropped"); // R10

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (nmi_pulse == '0 && lrst_pulse == '0 && !err_flag)) else $error("reset leak"); // R11

endmodule

// File: tb/core_event_router_tb.sv
`timescale 1ns/1ps
module core_event_router_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] sel_pad = 4'd0;
   logic       lrst_n_pad = 1'b1;
   logic       nmi_n_pad = 1'b1;
   logic       stb_n_pad = 1'b1;
   logic       err_clr = 1'b0;
   logic [7:0] nmi_pulse, lrst_pulse;
   logic       err_flag;

   int n_tot = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   core_event_router dut_i (
      .clk(clk), .rst(rst), .sel_pad(sel_pad), .lrst_n_pad(lrst_n_pad),
      .nmi_n_pad(nmi_n_pad), .stb_n_pad(stb_n_pad), .err_clr(err_clr),
      .nmi_pulse(nmi_pulse), .lrst_pulse(lrst_pulse), .err_flag(err_flag));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tot++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // One request: setup_c cycles of quiet inputs, strobe low for low_c cycles,
   // optional change during low (mid_chg) or after rise (hold_chg).
   task automatic run_req(input logic [3:0] sel, input logic l, input logic n,
                          input int setup_c, input int low_c, input int mid_chg,
                          input int hold_chg, input string tag);
      logic [7:0] vec, exp_n, exp_l, bad_n, bad_l, eb_n, eb_l;
      bit good, exp_err, ok_n, ok_l;
      good    = (setup_c >= 16) && (low_c >= 12) && (mid_chg < 0);
      exp_err = !good || (hold_chg >= 0);
      vec     = sel[3] ? 8'hFF : (8'h01 << sel[2:0]);
      exp_l   = (good && l == 1'b0) ? vec : 8'h00;
      exp_n   = (good && l == 1'b1 && n == 1'b0) ? vec : 8'h00;
      @(negedge clk);
      sel_pad = sel; lrst_n_pad = l; nmi_n_pad = n;
      repeat (setup_c) @(negedge clk);
      stb_n_pad = 1'b0;
      for (int k = 0; k < low_c; k++) begin
         @(negedge clk);
         if (k == mid_chg) sel_pad[0] = ~sel_pad[0];
      end
      stb_n_pad = 1'b1;
      ok_n = 1'b1; ok_l = 1'b1; bad_n = 8'h00; bad_l = 8'h00; eb_n = exp_n; eb_l = exp_l;
      for (int i = 1; i <= 24; i++) begin
         @(negedge clk);
         if (nmi_pulse != ((i == 3) ? exp_n : 8'h00) && ok_n) begin
            ok_n = 1'b0; bad_n = nmi_pulse; eb_n = (i == 3) ? exp_n : 8'h00;
         end
         if (lrst_pulse != ((i == 3) ? exp_l : 8'h00) && ok_l) begin
            ok_l = 1'b0; bad_l = lrst_pulse; eb_l = (i == 3) ? exp_l : 8'h00;
         end
         if (i == hold_chg) sel_pad[0] = ~sel_pad[0];
      end
      chk(ok_n, tag, "nmi window (R5 slot 3)", ok_n ? exp_n : bad_n, eb_n);
      chk(ok_l, tag, "lrst window (R5 slot 3)", ok_l ? exp_l : bad_l, eb_l);
      chk(err_flag == exp_err, tag, "err_flag (R10 sticky)", err_flag, exp_err);
      lrst_n_pad = 1'b1; nmi_n_pad = 1'b1;
      if (err_flag) begin
         err_clr = 1'b1;
         @(negedge clk);
         err_clr = 1'b0;
         chk(err_flag == 1'b0, "R10", "err after clear", err_flag, 0);
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      n_tot++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

   initial begin : main
      // R11: strobe already low with an interrupt request during reset
      stb_n_pad = 1'b0; nmi_n_pad = 1'b0; sel_pad = 4'd2;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(nmi_pulse == 8'h00, "R11", "nmi after reset", nmi_pulse, 0);
      chk(lrst_pulse == 8'h00, "R11", "lrst after reset", lrst_pulse, 0);
      chk(err_flag == 1'b0, "R11", "err after reset", err_flag, 0);
      repeat (20) @(negedge clk);
      stb_n_pad = 1'b1;
      begin
         bit seen;
         seen = 1'b0;
         for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (nmi_pulse != 8'h00 || lrst_pulse != 8'h00) seen = 1'b1;
         end
         chk(!seen, "R11", "stale low strobe ignored", seen, 0);
         chk(err_flag == 1'b0, "R11", "no err from stale strobe", err_flag, 0);
      end
      nmi_n_pad = 1'b1;
      repeat (20) @(negedge clk);

      // R1/R2 sweep at minimum width (R6 accept boundary)
      for (int s = 0; s < 16; s++) run_req(4'(s), 1'b1, 1'b0, 16, 12, -1, -1, "R1/R2/R6");
      // R3 sweep of local reset
      for (int s = 0; s < 16; s++) run_req(4'(s), 1'b0, 1'b1, 16, 14, -1, -1, "R1/R3");
      // R3 priority
      run_req(4'd3, 1'b0, 1'b0, 16, 13, -1, -1, "R3");
      run_req(4'd9, 1'b0, 1'b0, 16, 13, -1, -1, "R3");
      // R4 no action
      run_req(4'd5, 1'b1, 1'b1, 16, 12, -1, -1, "R4");
      run_req(4'd12, 1'b1, 1'b1, 16, 20, -1, -1, "R4");
      // R6 too short
      run_req(4'd1, 1'b1, 1'b0, 16, 11, -1, -1, "R6");
      run_req(4'd8, 1'b0, 1'b1, 16, 1, -1, -1, "R6");
      // R7 change while low
      run_req(4'd4, 1'b1, 1'b0, 16, 14, 5, -1, "R7");
      run_req(4'd6, 1'b0, 1'b1, 16, 14, 0, -1, "R7");
      // R8 short setup
      run_req(4'd2, 1'b1, 1'b0, 4, 14, -1, -1, "R8");
      run_req(4'd7, 1'b0, 1'b1, 2, 14, -1, -1, "R8");
      // R9 change after rise
      run_req(4'd1, 1'b1, 1'b0, 16, 14, -1, 2, "R9");
      run_req(4'd10, 1'b0, 1'b1, 16, 14, -1, 6, "R9");
      // request still accepted after error recovery
      run_req(4'd0, 1'b1, 1'b0, 16, 12, -1, -1, "R2");

      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

endmodule